// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address sequence for a four-beat memory burst. A begin-burst load captures a full address. The two low bits of that address become the burst start, and the upper bits are held unchanged for the whole burst. Each step pulse then moves the low bits to the next beat. A run-time order input picks one of two orders. In interleaved order the low bits are the start XOR a beat count. In linear order they are the start plus the beat count, wrapped within the four-beat block.

The output is taken from registers through one XOR or adder stage. A load or step seen at a rising clock edge shows at the output straight after that edge. The order input is meant to be tied off or changed only between bursts. The block can sit beside a registered address path in a synchronous memory controller, a cache fill engine or a burst-capable bus slave.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) sets burst_addr to all zeros.
- R2: At the edge after load is high, burst_addr equals the load_addr sampled at that edge, in either order.
- R3: With interleave high (1 = interleaved order), each step after a start of low bits s gives s^1, then s^2, then s^3. Bit 0 of the address inverts on every step.
- R4: With interleave low (0 = linear order), each step adds one to the two low bits modulo 4. For example, a start of 2'b10 gives 11, 00, 01.
- R5: Address bits above bit 1 do not change on any edge without a load.
- R6: With load and step both low, burst_addr holds its value.
- R7: The step after the fourth beat returns the low bits to the start value loaded at the beginning of the burst.
- R8: When load and step are both high at the same edge, the load wins. burst_addr equals load_addr, and the beat count restarts from the first beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Begin burst: capture load_addr and clear the beat count |
| load_addr | input | ADDR_W | External start address |
| step | input | 1 | Advance to the next beat (high = advance, low = hold) |
| interleave | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| burst_addr | output | ADDR_W | Current burst address |

## Verification
The checker tests these properties on every cycle:
- a load returns the captured address one edge later, even when a step arrives with it;
- the upper bits never move without a load;
- a held cycle leaves the address unchanged;
- a linear step adds one to the low bits;
- an interleaved step always inverts bit 0.

The full interleaved sequence needs the start value, which a one-cycle property does not keep. So the bench's vectors cover the exact s^2 and s^3 beats, the wrap back to the start after the fourth beat, and the reset value, including a reset in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // Encoding of the order-select input
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   // Smallest legal address width for a given beat-field width
   function automatic int unsigned min_addr_w(input int unsigned beat_w);
      return beat_w + 1;
   endfunction

endpackage

// File: rtl/burst_start_reg.sv
// Holds the address captured at the start of a burst.
module burst_start_reg #(
   parameter int unsigned ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   output logic [ADDR_W-1:0] start_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
      end else if (load) begin
         start_q <= load_addr;
      end
   end

endmodule

// File: rtl/burst_beat_ctr.sv
// Beat counter: cleared by load (load has priority), advanced by step.
module burst_beat_ctr #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [BEAT_W-1:0] beat_q
);

   localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (load) begin
         beat_q <= '0;
      end else if (step) begin
         beat_q <= beat_q + BEAT_ONE;   // wraps naturally modulo 2**BEAT_W
      end
   end

endmodule

// File: rtl/burst_order_map.sv
// Maps the start low bits and the beat count to the current low bits.
module burst_order_map
   import burst_pkg::*;
#(
   parameter int unsigned BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start_lo,
   input  logic [BEAT_W-1:0] beat,
   input  burst_order_e      order,
   output logic [BEAT_W-1:0] cur_lo
);

   logic [BEAT_W-1:0] xor_lo;
   logic [BEAT_W-1:0] sum_lo;

   // Interleaved: each low bit is flipped by the matching count bit
   for (genvar b = 0; b < BEAT_W; b++) begin : g_flip
      assign xor_lo[b] = start_lo[b] ^ beat[b];
   end

   // Linear: modular add within the block
   assign sum_lo = start_lo + beat;

   always_comb begin
      unique case (order)
         ORD_INTERLEAVE: cur_lo = xor_lo;
         default:        cur_lo = sum_lo;
      endcase
   end

endmodule

// File: rtl/burst_addr_gen.sv
// Burst address generator with run-time selectable beat order.
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   input  logic              interleave,
   output logic [ADDR_W-1:0] burst_addr
);

   localparam int unsigned HI_W = ADDR_W - BEAT_W;

   // Elaboration-time parameter checks
   if (BEAT_W < 1) begin : g_bad_beat
      $error("burst_addr_gen: BEAT_W must be at least 1");
   end
   if (ADDR_W < min_addr_w(BEAT_W)) begin : g_bad_addr
      $error("burst_addr_gen: ADDR_W must exceed BEAT_W");
   end

   logic [ADDR_W-1:0] start_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] cur_lo;
   burst_order_e      order;

   assign order = burst_order_e'(interleave);

   burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (load_addr),
      .start_q   (start_q)
   );

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .beat_q (beat_q)
   );

   burst_order_map #(.BEAT_W(BEAT_W)) u_map (
      .start_lo (start_q[BEAT_W-1:0]),
      .beat     (beat_q),
      .order    (order),
      .cur_lo   (cur_lo)
   );

   logic [HI_W-1:0] hi_part;
   assign hi_part    = start_q[ADDR_W-1:BEAT_W];
   assign burst_addr = {hi_part, cur_lo};

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Property checker bound to burst_addr_gen.
module burst_addr_gen_chk #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load,
   input logic [ADDR_W-1:0] load_addr,
   input logic              step,
   input logic              interleave,
   input logic [ADDR_W-1:0] burst_addr
);

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   // Tracks whether at least one edge has passed since reset, so that $past is valid
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R2: load returns the captured address on the next edge
   a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> burst_addr == $past(load_addr));

   // R8: load beats step in the same cycle
   a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (load && step) |=> burst_addr == $past(load_addr));

   // R5: upper bits keep their value without a load
   a_r5_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !load) |=> burst_addr[ADDR_W-1:BEAT_W] == $past(burst_addr[ADDR_W-1:BEAT_W]));

   // R6: a held cycle keeps the address when the order input is unchanged
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !load && !step) |=>
         (interleave != $past(interleave)) || (burst_addr == $past(burst_addr)));

   // R4: a linear step adds one to the low bits
   a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !load && step && !interleave) |=>
         (interleave != $past(interleave)) ||
         (burst_addr[BEAT_W-1:0] == $past(burst_addr[BEAT_W-1:0]) + ONE));

   // R3: an interleaved step always inverts bit 0
   a_r3_inter_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !load && step && interleave) |=>
         (interleave != $past(interleave)) ||
         (burst_addr[0] != $past(burst_addr[0])));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load       (load),
   .load_addr  (load_addr),
   .step       (step),
   .interleave (interleave),
   .burst_addr (burst_addr)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          load;
   logic [AW-1:0] load_addr;
   logic          step;
   logic          interleave;
   logic [AW-1:0] burst_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_addr  (load_addr),
      .step       (step),
      .interleave (interleave),
      .burst_addr (burst_addr)
   );

   // Vector fields: {load, step, interleave, load_addr[17:0], expected[17:0]}
   localparam int NV = 18;
   localparam logic [38:0] VEC [NV] = '{
      {1'b1, 1'b0, 1'b0, 18'h1F0E6, 18'h1F0E6},  // R2 linear load, start 10
      {1'b0, 1'b1, 1'b0, 18'h00000, 18'h1F0E7},  // R4 10 -> 11
      {1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h1F0E7},  // R6 hold, load_addr ignored
      {1'b0, 1'b1, 1'b0, 18'h00000, 18'h1F0E4},  // R4 11 -> 00 wrap
      {1'b0, 1'b1, 1'b0, 18'h00000, 18'h1F0E5},  // R4 00 -> 01
      {1'b0, 1'b1, 1'b0, 18'h00000, 18'h1F0E6},  // R7 back to start
      {1'b1, 1'b0, 1'b1, 18'h2A5C5, 18'h2A5C5},  // R2 interleaved load, start 01
      {1'b0, 1'b1, 1'b1, 18'h00000, 18'h2A5C4},  // R3 s^1
      {1'b0, 1'b1, 1'b1, 18'h00000, 18'h2A5C7},  // R3 s^2
      {1'b0, 1'b1, 1'b1, 18'h00000, 18'h2A5C6},  // R3 s^3
      {1'b0, 1'b1, 1'b1, 18'h00000, 18'h2A5C5},  // R7 wrap to start
      {1'b1, 1'b1, 1'b1, 18'h00003, 18'h00003},  // R8 load wins over step
      {1'b0, 1'b1, 1'b1, 18'h00000, 18'h00002},  // R8/R3 count restarted: 11^01
      {1'b0, 1'b1, 1'b1, 18'h00000, 18'h00001},  // R3 11^10
      {1'b0, 1'b0, 1'b1, 18'h00000, 18'h00001},  // R6 hold
      {1'b0, 1'b1, 1'b1, 18'h00000, 18'h00000},  // R3 11^11
      {1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h3FFFF},  // R8 linear load with step
      {1'b0, 1'b1, 1'b0, 18'h00000, 18'h3FFFC}   // R5 upper bits kept on wrap
   };

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Apply inputs after a falling edge, then sample after the next falling edge
   task automatic cycle(input logic ld, input logic st, input logic md, input logic [AW-1:0] a);
      load = ld; step = st; interleave = md; load_addr = a;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0; load = 1'b0; step = 1'b0; interleave = 1'b1; load_addr = '0;
      @(negedge clk);
      cycle(1'b0, 1'b0, 1'b1, '0);
      check("R1 reset value", burst_addr, '0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         cycle(VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:18]);
         check($sformatf("table entry %0d (R2 R3 R4 R5 R6 R7 R8)", i), burst_addr, VEC[i][17:0]);
      end

      // R4 linear full loop from start 01, followed by wrap (R7)
      cycle(1'b1, 1'b0, 1'b0, 18'h12341);
      check("R2 load 12341", burst_addr, 18'h12341);
      cycle(1'b0, 1'b1, 1'b0, '0);
      check("R4 01->10", burst_addr, 18'h12342);
      cycle(1'b0, 1'b1, 1'b0, '0);
      check("R4 10->11", burst_addr, 18'h12343);
      cycle(1'b0, 1'b1, 1'b0, '0);
      check("R4 11->00", burst_addr, 18'h12340);
      cycle(1'b0, 1'b1, 1'b0, '0);
      check("R7 linear wrap", burst_addr, 18'h12341);

      // R6 several holds in a row with a changing load_addr
      for (int k = 0; k < 3; k++) begin
         cycle(1'b0, 1'b0, 1'b0, AW'(k * 18'h0A5A5));
         check("R6 repeated hold", burst_addr, 18'h12341);
      end

      // R1 reset in mid-burst
      cycle(1'b1, 1'b0, 1'b1, 18'h3C3C2);
      cycle(1'b0, 1'b1, 1'b1, '0);
      check("R3 mid-burst before reset", burst_addr, 18'h3C3C3);
      rst_n = 1'b0;
      cycle(1'b0, 1'b1, 1'b1, '0);
      check("R1 reset mid-burst", burst_addr, '0);
      rst_n = 1'b1;
      cycle(1'b0, 1'b0, 1'b1, '0);
      check("R1 stays zero after reset", burst_addr, '0);

      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule